// File: doc/BRIEF.md
# Free-Running 16-bit Timer Counter

This block is a 16-bit up-counter that never stops, with a byte-wide register port for an 8-bit processor. The count can be read through two views, a primary one and an alternate one, each split into a high byte and a low byte. Reading a high byte captures the matching low byte, so a high-then-low pair of reads gives a consistent 16-bit value even while the counter moves. The counter is never cleared to zero. Reset and any write to either low-byte register put it at FFFCh, which is the only value it is ever loaded with.

The count advances from one of two sources. The first is the core clock divided by 2, 4 or 8. The second is an external clock input, which passes through a synchronizer and counts on its rising or falling edge, as chosen. When the count wraps from FFFFh to 0000h, an overflow flag sets in the status register. An interrupt request follows the flag when it is enabled. The flag clears only after a status read that sees it set, followed by a read of the primary low byte. The alternate view exists so that software can sample the count without touching the flag.

Top module: `free_run_timer`

## Requirements
- R1: After reset the count is FFFCh. The control byte (address 0) and the status byte (address 1) read 00h, and `ovf_irq` is low.
- R2: With control bit 3 = 0 (internal source), the count rises by one every N core clocks, where control bits [2:1] give N: 00 gives 2, 01 gives 4, 10 and 11 give 8. m cycles after a reload the count is FFFCh + floor(m/N).
- R3: A write of any data to address 3 (primary low) or address 5 (alternate low) loads FFFCh and restarts the prescaler. Writes to address 1 (status), 2 (primary high) and 4 (alternate high) leave the count unchanged.
- R4: Addresses 2/3 (primary high/low) and 4/5 (alternate high/low) return the same count value. The count registers are read-only.
- R5: A read of a view's high byte captures the low byte. That view's next low-byte read returns the captured byte even if the count has advanced. A low-byte read with no capture pending returns the live low byte.
- R6: With control bit 3 = 1 (external source), the count rises once per active edge of `ext_clk`. Control bit 4 picks the edge: 0 for rising, 1 for falling. The edge passes through two synchronizer flops, so the count changes at the third clock edge after the input changes. The opposite edge and the prescaler have no effect in this mode.
- R7: The overflow flag, status bit 7, sets when the count wraps from FFFFh to 0000h.
- R8: The flag clears only on a primary low-byte read (address 3) that follows a status read which saw the flag set. A primary low-byte read without that status read does not clear it, and an alternate low-byte read never clears it.
- R9: `ovf_irq` is high exactly when the overflow flag and control bit 0 (interrupt enable) are both set.
- R10: The control register at address 0 reads back the full byte last written. Bits 7:5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe, one cycle per read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd`, 00h otherwise |
| ext_clk | input | 1 | External count clock, at least 4 times slower than `clk` |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The in-module assertions check several rules on every cycle: the reload on a low-byte write, the single step per increment enable, that the count holds when there is no enable, the gap between prescaler ticks, the one-cycle width of each synchronized edge, the setting and holding of the overflow flag, and the fact that an alternate low read never clears the flag. Other behaviours depend on a sequence of bus accesses or on absolute timing, so only the bench scenarios can show them. These are the divider period for each control setting, the three-edge latency of the external clock, the value held for coherent reads while the counter moves, the status-then-low-read order that clears the flag, and the interrupt masking.

// File: rtl/tmr_pkg.sv
// Shared definitions for the free-running timer: register addresses and
// control/status bit positions. Assumes an 8-bit register port.
package tmr_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_STAT   = 3'd1,
        REG_CNT_HI = 3'd2,
        REG_CNT_LO = 3'd3,
        REG_ALT_HI = 3'd4,
        REG_ALT_LO = 3'd5,
        REG_RSV6   = 3'd6,
        REG_RSV7   = 3'd7
    } reg_addr_e;

    localparam int CTRL_IE_BIT   = 0;
    localparam int CTRL_DIV_LSB  = 1;
    localparam int CTRL_DIV_MSB  = 2;
    localparam int CTRL_SRC_BIT  = 3;
    localparam int CTRL_EDGE_BIT = 4;
    localparam int STAT_OVF_BIT  = 7;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } clk_src_e;

endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: a free-running counter that makes a one-cycle tick every
// 2^(div_sel+1) clocks, with the exponent capped at PRESC_W.
// Assumes: restart puts the phase back to zero, so the first tick comes
// N cycles after the restart.
module tmr_prescaler #(
    parameter int PRESC_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] div_sel,
    output logic       tick
);

    logic [PRESC_W-1:0] phase_q;
    logic [PRESC_W-1:0] mask;

    // Build the mask of low phase bits that must all be set for a tick.
    always_comb begin
        int unsigned k;
        k = int'(div_sel) + 1;
        if (k > PRESC_W) k = PRESC_W;
        for (int i = 0; i < PRESC_W; i++) begin
            mask[i] = (i < k);
        end
    end

    assign tick = ((phase_q & mask) == mask);

    // Advance the phase every cycle; clear it on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase_q <= '0;
        else                   phase_q <= phase_q + 1'b1;
    end

    // R2: two ticks are never back to back, because every divider is at least 2.
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> !tick);

    // R3: a restart puts the phase where no tick can follow at once.
    assert_restart_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

endmodule

// File: rtl/tmr_edge_sync.sv
// External clock conditioner: a STAGES-deep synchronizer, then an edge
// detector that gives one-cycle pulses on the selected edge.
// Assumes: async_in is at least 4 times slower than clk and is low when
// reset is released. STAGES is at least 2.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic falling_sel,
    output logic edge_pulse
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;
    logic              rise;
    logic              fall;

    // Shift the raw input through the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign cur        = sync_q[STAGES-1];
    assign rise       = cur & ~prev_q;
    assign fall       = ~cur & prev_q;
    assign edge_pulse = falling_sel ? fall : rise;

    // R6: each synchronized rising edge gives exactly one pulse.
    assert_single_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R6: each synchronized falling edge gives exactly one pulse.
    assert_single_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tmr_count_core.sv
// Counter core: the up-counter, which loads RELOAD on reset and on a load
// request, and the sticky overflow flag set on the all-ones to zero wrap.
// Assumes: load has priority over inc, and setting the flag has priority
// over clearing it.
module tmr_count_core #(
    parameter int              CNT_W  = 16,
    parameter logic [CNT_W-1:0] RELOAD = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);

    logic [CNT_W-1:0] count_q;
    logic             flag_q;
    logic             wrap;

    assign wrap = inc && !load && (count_q == {CNT_W{1'b1}});

    // Count register: reload on reset or load, step on inc.
    always_ff @(posedge clk) begin
        if (!rst_n)   count_q <= RELOAD;
        else if (load) count_q <= RELOAD;
        else if (inc)  count_q <= count_q + 1'b1;
    end

    // Overflow flag: set on wrap, clear on a qualified clear request.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (wrap)    flag_q <= 1'b1;
        else if (ovf_clr) flag_q <= 1'b0;
    end

    assign count    = count_q;
    assign ovf_flag = flag_q;

    // R3: a load always leaves the count at the reload value.
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == RELOAD));

    // R2: an increment with no load moves the count by exactly one.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (count_q == $past(count_q) + 1'b1));

    // R6: with no increment and no load the count holds.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(count_q));

    // R7: stepping from all ones sets the flag.
    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && count_q == {CNT_W{1'b1}}) |=> flag_q);

    // R8: without a clear request the flag stays set.
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ovf_clr) |=> flag_q);

endmodule

// File: rtl/tmr_read_view.sv
// Coherent read view: a high-byte read captures the low byte, and the next
// low-byte read returns the capture. Otherwise the low byte is live.
// Assumes: each view has its own instance, so the views do not disturb
// each other.
module tmr_read_view #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_rd,
    input  logic              lo_rd,
    input  logic [DATA_W-1:0] live_lo,
    output logic [DATA_W-1:0] lo_out
);

    logic [DATA_W-1:0] held_q;
    logic              pending_q;

    // Capture the low byte on a high read; release it on a low read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q    <= '0;
            pending_q <= 1'b0;
        end else if (hi_rd) begin
            held_q    <= live_lo;
            pending_q <= 1'b1;
        end else if (lo_rd) begin
            pending_q <= 1'b0;
        end
    end

    assign lo_out = pending_q ? held_q : live_lo;

    // R5: a high-byte read always leaves a capture pending.
    assert_capture_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |=> pending_q);

    // R5: a low-byte read with no high read releases the capture.
    assert_capture_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd && !hi_rd) |=> !pending_q);

endmodule

// File: rtl/free_run_timer.sv
// Free-running timer top: decodes the byte register port, holds the
// control byte, picks the count source, arms the flag clearing sequence
// and muxes the read data. Assumes one access per cycle (bus_rd and bus_wr
// are not both high) and CNT_W = 2 * DATA_W.
module free_run_timer #(
    parameter int DATA_W      = 8,
    parameter int PRESC_W     = 3,
    parameter int SYNC_STAGES = 2,
    parameter logic [2*DATA_W-1:0] RELOAD = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk,
    output logic              ovf_irq
);
    import tmr_pkg::*;

    localparam int CNT_W   = 2 * DATA_W;
    localparam int N_VIEWS = 2;

    reg_addr_e         addr;
    logic [DATA_W-1:0] ctrl_q;
    logic              arm_q;
    logic              rd_stat, rd_cnt_hi, rd_cnt_lo, rd_alt_hi, rd_alt_lo;
    logic              wr_ctrl, reload;
    logic              presc_tick, ext_pulse, inc;
    logic              ovf_flag, ovf_clr;
    logic [CNT_W-1:0]  count;
    clk_src_e          src;
    logic [N_VIEWS-1:0] view_hi_rd, view_lo_rd;
    logic [DATA_W-1:0] view_lo [N_VIEWS];

    assign addr = reg_addr_e'(bus_addr);

    // Decode the strobes for each register.
    always_comb begin
        rd_stat   = bus_rd && (addr == REG_STAT);
        rd_cnt_hi = bus_rd && (addr == REG_CNT_HI);
        rd_cnt_lo = bus_rd && (addr == REG_CNT_LO);
        rd_alt_hi = bus_rd && (addr == REG_ALT_HI);
        rd_alt_lo = bus_rd && (addr == REG_ALT_LO);
        wr_ctrl   = bus_wr && (addr == REG_CTRL);
        reload    = bus_wr && ((addr == REG_CNT_LO) || (addr == REG_ALT_LO));
    end

    // Control register: stores the full written byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata;
    end

    assign src = clk_src_e'(ctrl_q[CTRL_SRC_BIT]);

    tmr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (reload),
        .div_sel (ctrl_q[CTRL_DIV_MSB:CTRL_DIV_LSB]),
        .tick    (presc_tick)
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .async_in    (ext_clk),
        .falling_sel (ctrl_q[CTRL_EDGE_BIT]),
        .edge_pulse  (ext_pulse)
    );

    assign inc = (src == SRC_EXTERNAL) ? ext_pulse : presc_tick;

    // Clear sequence: a status read that sees the flag arms; a primary low read disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)                   arm_q <= 1'b0;
        else if (rd_cnt_lo)           arm_q <= 1'b0;
        else if (rd_stat && ovf_flag) arm_q <= 1'b1;
    end

    assign ovf_clr = rd_cnt_lo && arm_q;

    tmr_count_core #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .inc      (inc),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .ovf_flag (ovf_flag)
    );

    assign view_hi_rd = {rd_alt_hi, rd_cnt_hi};
    assign view_lo_rd = {rd_alt_lo, rd_cnt_lo};

    // One coherent capture per read view: index 0 primary, index 1 alternate.
    for (genvar v = 0; v < N_VIEWS; v++) begin : g_view
        tmr_read_view #(.DATA_W(DATA_W)) u_view (
            .clk     (clk),
            .rst_n   (rst_n),
            .hi_rd   (view_hi_rd[v]),
            .lo_rd   (view_lo_rd[v]),
            .live_lo (count[DATA_W-1:0]),
            .lo_out  (view_lo[v])
        );
    end

    // Read data mux, gated by the read strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (addr)
                REG_CTRL:   bus_rdata = ctrl_q;
                REG_STAT:   bus_rdata[STAT_OVF_BIT] = ovf_flag;
                REG_CNT_HI: bus_rdata = count[CNT_W-1:DATA_W];
                REG_CNT_LO: bus_rdata = view_lo[0];
                REG_ALT_HI: bus_rdata = count[CNT_W-1:DATA_W];
                REG_ALT_LO: bus_rdata = view_lo[1];
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign ovf_irq = ovf_flag & ctrl_q[CTRL_IE_BIT];

    // R8: an alternate low-byte read never clears a set flag.
    assert_alt_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_alt_lo && ovf_flag) |=> ovf_flag);

    // R8: a primary low-byte read always ends the clear sequence.
    assert_arm_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt_lo |=> !arm_q);

endmodule

// File: tb/tb_free_run_timer.sv
// Scoreboard bench: the driver tasks push expected read bytes into a
// queue, and a monitor pops them and compares with bus_rdata at the
// falling edge of a read cycle.
module tb_free_run_timer;
    import tmr_pkg::*;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       ovf_irq;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    free_run_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_clk   (ext_clk),
        .ovf_irq   (ovf_irq)
    );

    // Monitor: compare each read cycle with the oldest expected item.
    always @(negedge clk) begin
        if (bus_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expected item, actual %02h expected none", bus_rdata);
            end else begin
                exp_t item;
                item = exp_q.pop_front();
                if (bus_rdata !== item.val) begin
                    errors++;
                    $display("FAIL %s: addr %0d actual %02h expected %02h",
                             item.req, bus_addr, bus_rdata, item.val);
                end
            end
        end
    end

    // Driver tasks are entered 1 ns after a rising edge and return likewise.
    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
        bus_rd   = 1'b1;
        bus_addr = a;
        exp_q.push_back('{val: e, req: req});
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic ext_set(input logic v);
        ext_clk = v;
        idle(5);
    endtask

    task automatic chk(input logic act, input logic e, input string req);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: ovf_irq actual %0b expected %0b", req, act, e);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state (internal div-2 count is still at FFFCh for two cycles)
        rd(REG_CNT_HI, 8'hFF, "R1");
        rd(REG_CNT_LO, 8'hFC, "R1");
        rd(REG_STAT,   8'h00, "R1");
        rd(REG_CTRL,   8'h00, "R1");
        chk(ovf_irq, 1'b0, "R1");

        // Go to external rising mode and reload; both views must agree (R4)
        wr(REG_CTRL, 8'h08);
        wr(REG_CNT_LO, 8'h55);
        rd(REG_ALT_HI, 8'hFF, "R4");
        rd(REG_ALT_LO, 8'hFC, "R4");
        rd(REG_CNT_HI, 8'hFF, "R4");
        rd(REG_CNT_LO, 8'hFC, "R4");

        // R10: full control byte read back; bits 7:5 have no effect
        wr(REG_CTRL, 8'hE8);
        rd(REG_CTRL, 8'hE8, "R10");
        idle(10);
        rd(REG_ALT_LO, 8'hFC, "R10");
        wr(REG_CTRL, 8'h08);

        // R6: synchronizer latency, change on the third edge after input change
        ext_clk = 1'b1;
        rd(REG_ALT_LO, 8'hFC, "R6");
        rd(REG_ALT_LO, 8'hFC, "R6");
        rd(REG_ALT_LO, 8'hFC, "R6");
        rd(REG_ALT_LO, 8'hFD, "R6");
        ext_set(1'b0);
        rd(REG_ALT_LO, 8'hFD, "R6");
        wr(REG_CTRL, 8'h18);
        ext_set(1'b1);
        rd(REG_ALT_LO, 8'hFD, "R6");
        ext_set(1'b0);
        rd(REG_ALT_LO, 8'hFE, "R6");
        wr(REG_CTRL, 8'h08);
        idle(20);
        rd(REG_ALT_LO, 8'hFE, "R6");

        // R3: writes to high bytes and status are ignored; alternate low write reloads
        wr(REG_CNT_HI, 8'h12);
        wr(REG_ALT_HI, 8'h34);
        wr(REG_STAT,   8'hFF);
        rd(REG_ALT_HI, 8'hFF, "R3");
        rd(REG_ALT_LO, 8'hFE, "R3");
        wr(REG_ALT_LO, 8'h00);
        rd(REG_CNT_HI, 8'hFF, "R3");
        rd(REG_CNT_LO, 8'hFC, "R3");

        // R5: the captured low byte survives a count change, per view
        rd(REG_CNT_HI, 8'hFF, "R5");
        ext_set(1'b1);
        rd(REG_CNT_LO, 8'hFC, "R5");
        rd(REG_CNT_LO, 8'hFD, "R5");
        ext_set(1'b0);
        rd(REG_ALT_HI, 8'hFF, "R5");
        ext_set(1'b1);
        rd(REG_ALT_LO, 8'hFD, "R5");
        rd(REG_ALT_LO, 8'hFE, "R5");
        ext_set(1'b0);

        // R7: wrap from FFFFh to 0000h sets the flag
        rd(REG_STAT, 8'h00, "R7");
        ext_set(1'b1);
        ext_set(1'b0);
        rd(REG_STAT,   8'h00, "R7");
        rd(REG_ALT_HI, 8'hFF, "R7");
        rd(REG_ALT_LO, 8'hFF, "R7");
        ext_set(1'b1);
        ext_set(1'b0);
        rd(REG_ALT_HI, 8'h00, "R7");
        rd(REG_ALT_LO, 8'h00, "R7");

        // R9: interrupt gated by the enable bit
        chk(ovf_irq, 1'b0, "R9");
        wr(REG_CTRL, 8'h09);
        chk(ovf_irq, 1'b1, "R9");
        wr(REG_CTRL, 8'h08);
        chk(ovf_irq, 1'b0, "R9");
        wr(REG_CTRL, 8'h09);

        // R8: the clear sequence
        rd(REG_CNT_LO, 8'h00, "R8");
        chk(ovf_irq, 1'b1, "R8");
        rd(REG_STAT, 8'h80, "R8");
        rd(REG_ALT_LO, 8'h00, "R8");
        chk(ovf_irq, 1'b1, "R8");
        rd(REG_CNT_LO, 8'h00, "R8");
        chk(ovf_irq, 1'b0, "R8");
        rd(REG_STAT, 8'h00, "R8");

        // R2: internal divider periods after a reload restart
        wr(REG_CTRL, 8'h00);
        wr(REG_CNT_LO, 8'h00);
        idle(5);
        rd(REG_ALT_LO, 8'hFE, "R2");
        wr(REG_CTRL, 8'h02);
        wr(REG_CNT_LO, 8'h00);
        idle(7);
        rd(REG_ALT_LO, 8'hFD, "R2");
        rd(REG_ALT_LO, 8'hFE, "R2");
        wr(REG_CTRL, 8'h04);
        wr(REG_CNT_LO, 8'h00);
        idle(7);
        rd(REG_ALT_LO, 8'hFC, "R2");
        rd(REG_ALT_LO, 8'hFD, "R2");
        wr(REG_CTRL, 8'h06);
        wr(REG_CNT_LO, 8'h00);
        idle(15);
        rd(REG_ALT_LO, 8'hFD, "R2");
        rd(REG_ALT_LO, 8'hFE, "R2");

        idle(2);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d items left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule